// File: doc/BRIEF.md
# Segmented Piecewise-Linear Nonlinearity Evaluator

This block turns a signed fixed-point argument into an approximation of one of three smooth nonlinear functions used by neuron models: the logistic sigmoid, the hyperbolic tangent and the natural exponential. It is purely combinational. Each function is stored as seventeen knot values at the integers from −8 to +8. The argument picks one unit-wide segment between two neighbouring knots, and the result is the straight line between those two knots, evaluated at the argument's fractional position.

Both the argument and the result use 16-bit two's-complement Q8.8: 8 integer bits and 8 fraction bits, so one LSB is 1/256. A 2-bit select chooses the function. Arguments outside the tabulated span are held at the nearest end knot. Every intermediate sum is clamped into the 16-bit signed range instead of wrapping. The exponential's large knots are clamped the same way.

A typical use is inside the state-update datapath of a fixed-point neuron. The membrane or gating expression feeds the argument, and the result goes straight into the next adder, in the same cycle.

Top module: `nl_seg_eval`

## Requirements
- R1: `arg_q` and `res_q` are signed Q8.8 (value = code / 256). `fsel` selects the function: 0 = sigmoid, 1 = tanh, 2 = exp.
- R2: For an argument whose integer part n = arg_q[15:8] (signed) lies in −8..7, the segment used is n + 8 (0..15). The interpolation weight is the unsigned low byte arg_q[7:0].
- R3: Inside the span, res_q = s + floor((e − s) · w / 256). Here s and e are the knot values at the segment's left and right ends, and w is the weight. The result never leaves the closed interval between s and e.
- R4: The knot for integer x (−8..8) is round(f(x) · 256), rounding half away from zero. Exp knots above 0x7FFF are held at 0x7FFF. Examples: sigmoid(1) = 187, tanh(−1) = −195, exp(4) = 13977.
- R5: Any argument with integer part below −8 (codes 0x8000..0xF7FF) yields exactly the knot at −8 for the selected function.
- R6: Any argument of +8.0 or more (codes 0x0800..0x7FFF) yields exactly the knot at +8 for the selected function.
- R7: Results are clamped to the 16-bit signed range. Sigmoid stays within 0..256, tanh within −256..256, and exp is never negative.
- R8: `fsel` = 3 is unused and forces `res_q` to 0 for every argument.
- R9: An in-span argument with a zero low byte yields exactly the knot at its integer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arg_q | input | 16 | Signed Q8.8 function argument |
| fsel | input | 2 | Function select: 0 sigmoid, 1 tanh, 2 exp, 3 unused (zero) |
| res_q | output | 16 | Signed Q8.8 approximated function value |

## Verification
The bound checker evaluates its checks on every change of the inputs. It confirms the per-function output bounds and the zero output for the unused select. It confirms that the result lies between the two knots of the chosen segment, and that out-of-span and zero-fraction arguments land exactly on a knot. None of these checks can tell a knot value that is off, a weight taken from the wrong bits, or a wrong rounding in the slope product. Only the bench can show those. It sweeps every argument code for every select and compares each result with a value it rebuilds from real-valued function evaluation and its own floor division.

// File: rtl/nl_seg_pkg.sv
package nl_seg_pkg;

  localparam int DATA_W  = 16;
  localparam int FRAC_W  = 8;
  localparam int INT_W   = DATA_W - FRAC_W;
  localparam int SEG_N   = 16;
  localparam int KNOT_N  = SEG_N + 1;
  localparam int SEG_W   = $clog2(SEG_N);
  localparam int KNOT_W  = $clog2(KNOT_N);
  localparam int SPAN_LO = -(SEG_N / 2);
  localparam int SPAN_HI = SEG_N / 2;
  localparam int DIFF_W  = DATA_W + 1;
  localparam int PROD_W  = DIFF_W + FRAC_W + 1;
  localparam int SUM_W   = DATA_W + 2;
  localparam int FUNC_N  = 3;

  typedef enum logic [1:0] {
    FN_SIGMOID = 2'd0,
    FN_TANH    = 2'd1,
    FN_EXP     = 2'd2,
    FN_OFF     = 2'd3
  } func_e;

  typedef logic signed [DATA_W-1:0] q_t;

  // Knot values at integer points -8..+8, index k = x + 8.
  function automatic q_t knot_val(input logic [1:0] fn, input logic [KNOT_W-1:0] k);
    q_t v;
    v = '0;
    unique case (fn)
      2'd0: begin
        case (k)
          5'd0, 5'd1: v = 16'sd0;
          5'd2:  v = 16'sd1;
          5'd3:  v = 16'sd2;
          5'd4:  v = 16'sd5;
          5'd5:  v = 16'sd12;
          5'd6:  v = 16'sd31;
          5'd7:  v = 16'sd69;
          5'd8:  v = 16'sd128;
          5'd9:  v = 16'sd187;
          5'd10: v = 16'sd225;
          5'd11: v = 16'sd244;
          5'd12: v = 16'sd251;
          5'd13: v = 16'sd254;
          5'd14: v = 16'sd255;
          default: v = 16'sd256;
        endcase
      end
      2'd1: begin
        case (k)
          5'd0, 5'd1, 5'd2, 5'd3, 5'd4: v = -16'sd256;
          5'd5:  v = -16'sd255;
          5'd6:  v = -16'sd247;
          5'd7:  v = -16'sd195;
          5'd8:  v = 16'sd0;
          5'd9:  v = 16'sd195;
          5'd10: v = 16'sd247;
          5'd11: v = 16'sd255;
          default: v = 16'sd256;
        endcase
      end
      2'd2: begin
        case (k)
          5'd0, 5'd1: v = 16'sd0;
          5'd2:  v = 16'sd1;
          5'd3:  v = 16'sd2;
          5'd4:  v = 16'sd5;
          5'd5:  v = 16'sd13;
          5'd6:  v = 16'sd35;
          5'd7:  v = 16'sd94;
          5'd8:  v = 16'sd256;
          5'd9:  v = 16'sd696;
          5'd10: v = 16'sd1892;
          5'd11: v = 16'sd5142;
          5'd12: v = 16'sd13977;
          default: v = 16'sd32767;
        endcase
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // Clamp a widened sum into the signed output range.
  function automatic q_t sat_q(input logic signed [SUM_W-1:0] x);
    logic signed [SUM_W-1:0] hi;
    logic signed [SUM_W-1:0] lo;
    hi = SUM_W'((1 << (DATA_W - 1)) - 1);
    lo = -SUM_W'(1 << (DATA_W - 1));
    if (x > hi)      return q_t'(hi);
    else if (x < lo) return q_t'(lo);
    else             return q_t'(x);
  endfunction

endpackage

// File: rtl/nl_seg_decode.sv
module nl_seg_decode
  import nl_seg_pkg::*;
(
  input  logic [DATA_W-1:0] arg_q,
  output logic [KNOT_W-1:0] k_lo,
  output logic [KNOT_W-1:0] k_hi,
  output logic [FRAC_W-1:0] wgt,
  output logic              below_span,
  output logic              above_span
);
  logic signed [INT_W-1:0] int_part;
  logic signed [INT_W:0]   seg_raw;

  always_comb begin
    int_part   = $signed(arg_q[DATA_W-1:FRAC_W]);
    seg_raw    = (INT_W+1)'(int_part) - (INT_W+1)'(SPAN_LO);
    below_span = int_part < (INT_W)'(SPAN_LO);
    above_span = int_part >= (INT_W)'(SPAN_HI);
    if (below_span) begin
      k_lo = '0;
      k_hi = '0;
      wgt  = '0;
    end else if (above_span) begin
      k_lo = KNOT_W'(SEG_N);
      k_hi = KNOT_W'(SEG_N);
      wgt  = '0;
    end else begin
      k_lo = KNOT_W'(seg_raw[SEG_W-1:0]);
      k_hi = KNOT_W'(seg_raw[SEG_W-1:0]) + KNOT_W'(1);
      wgt  = arg_q[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/nl_seg_knots.sv
module nl_seg_knots
  import nl_seg_pkg::*;
(
  input  logic [1:0]        fsel,
  input  logic [KNOT_W-1:0] k_lo,
  input  logic [KNOT_W-1:0] k_hi,
  output logic [DATA_W-1:0] y_start,
  output logic [DATA_W-1:0] y_end
);
  logic [DATA_W-1:0] s_fn [FUNC_N];
  logic [DATA_W-1:0] e_fn [FUNC_N];

  for (genvar g = 0; g < FUNC_N; g++) begin : g_fn
    always_comb begin
      s_fn[g] = knot_val(2'(g), k_lo);
      e_fn[g] = knot_val(2'(g), k_hi);
    end
  end

  always_comb begin
    if (fsel < 2'(FUNC_N)) begin
      y_start = s_fn[fsel];
      y_end   = e_fn[fsel];
    end else begin
      y_start = '0;
      y_end   = '0;
    end
  end
endmodule

// File: rtl/nl_seg_interp.sv
module nl_seg_interp
  import nl_seg_pkg::*;
(
  input  logic [DATA_W-1:0] y_start,
  input  logic [DATA_W-1:0] y_end,
  input  logic [FRAC_W-1:0] wgt,
  output logic [DATA_W-1:0] y_out
);
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    diff = DIFF_W'($signed(y_end)) - DIFF_W'($signed(y_start));
    prod = $signed(PROD_W'(diff)) * $signed(PROD_W'({1'b0, wgt}));
    sum  = SUM_W'($signed(y_start)) + $signed(prod[PROD_W-1:FRAC_W]);
    y_out = sat_q(sum);
  end
endmodule

// File: rtl/nl_seg_eval.sv
module nl_seg_eval
  import nl_seg_pkg::*;
(
  input  logic [15:0] arg_q,
  input  logic [1:0]  fsel,
  output logic [15:0] res_q
);
  logic [KNOT_W-1:0] k_lo;
  logic [KNOT_W-1:0] k_hi;
  logic [FRAC_W-1:0] wgt;
  logic              below_span;
  logic              above_span;
  logic [DATA_W-1:0] y_start;
  logic [DATA_W-1:0] y_end;
  logic [DATA_W-1:0] y_lin;

  nl_seg_decode u_dec (
    .arg_q      (arg_q),
    .k_lo       (k_lo),
    .k_hi       (k_hi),
    .wgt        (wgt),
    .below_span (below_span),
    .above_span (above_span)
  );

  nl_seg_knots u_knt (
    .fsel    (fsel),
    .k_lo    (k_lo),
    .k_hi    (k_hi),
    .y_start (y_start),
    .y_end   (y_end)
  );

  nl_seg_interp u_int (
    .y_start (y_start),
    .y_end   (y_end),
    .wgt     (wgt),
    .y_out   (y_lin)
  );

  assign res_q = (fsel == FN_OFF) ? '0 : y_lin;
endmodule

// File: rtl/nl_seg_eval_chk.sv
module nl_seg_eval_chk
  import nl_seg_pkg::*;
(
  input logic [15:0]       arg_q,
  input logic [1:0]        fsel,
  input logic [15:0]       res_q,
  input logic [KNOT_W-1:0] k_lo,
  input logic [DATA_W-1:0] y_start,
  input logic [DATA_W-1:0] y_end
);
  int r, s, e, lo, hi;
  logic in_span;

  always_comb begin
    r  = int'($signed(res_q));
    s  = int'($signed(y_start));
    e  = int'($signed(y_end));
    lo = (s < e) ? s : e;
    hi = (s < e) ? e : s;
    in_span = ($signed(arg_q) >= -16'sd2048) && ($signed(arg_q) < 16'sd2048);
    if (!$isunknown({arg_q, fsel, res_q})) begin
      AST_SIG_RANGE: assert (fsel != 2'd0 || (r >= 0 && r <= 256)); // R7
      AST_TANH_RANGE: assert (fsel != 2'd1 || (r >= -256 && r <= 256)); // R7
      AST_EXP_NONNEG: assert (fsel != 2'd2 || r >= 0); // R7
      AST_SEL_OFF_ZERO: assert (fsel != 2'd3 || r == 0); // R8
      AST_WITHIN_KNOTS: assert (fsel == 2'd3 || !in_span || (r >= lo && r <= hi)); // R3
      AST_BELOW_CLAMP: assert (fsel == 2'd3 || $signed(arg_q) >= -16'sd2048
                               || res_q == knot_val(fsel, '0)); // R5
      AST_ABOVE_CLAMP: assert (fsel == 2'd3 || $signed(arg_q) < 16'sd2048
                               || res_q == knot_val(fsel, KNOT_W'(SEG_N))); // R6
      AST_KNOT_HIT: assert (fsel == 2'd3 || !in_span || arg_q[7:0] != 8'd0
                            || res_q == knot_val(fsel, k_lo)); // R9
    end
  end
endmodule

bind nl_seg_eval nl_seg_eval_chk u_chk (
  .arg_q   (arg_q),
  .fsel    (fsel),
  .res_q   (res_q),
  .k_lo    (k_lo),
  .y_start (y_start),
  .y_end   (y_end)
);

// File: tb/nl_seg_eval_test.sv
module nl_seg_eval_test;
  logic        clk = 1'b0;
  logic [15:0] arg_q = '0;
  logic [1:0]  fsel = '0;
  logic [15:0] res_q;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nl_seg_eval uut (.arg_q(arg_q), .fsel(fsel), .res_q(res_q));

  function automatic int ref_knot(int fn, int k);
    real x, y;
    int v;
    x = real'(k - 8);
    case (fn)
      0: y = 1.0 / (1.0 + $exp(-x));
      1: y = ($exp(x) - $exp(-x)) / ($exp(x) + $exp(-x));
      default: y = $exp(x);
    endcase
    y = y * 256.0;
    v = (y >= 0.0) ? $rtoi($floor(y + 0.5)) : -$rtoi($floor(-y + 0.5));
    if (v > 32767) v = 32767;
    return v;
  endfunction

  function automatic int floor_div256(int n);
    if (n >= 0) return n / 256;
    return -((-n + 255) / 256);
  endfunction

  function automatic int ref_eval(int fn, int code);
    int a, ip, w, s, e;
    if (fn == 3) return 0;
    a = (code >= 32768) ? code - 65536 : code;
    if (a < -2048) return ref_knot(fn, 0);
    if (a >= 2048) return ref_knot(fn, 16);
    ip = floor_div256(a);
    w  = a - ip * 256;
    s  = ref_knot(fn, ip + 8);
    e  = ref_knot(fn, ip + 9);
    return floor_div256(s * 256 + (e - s) * w);
  endfunction

  function automatic string tag_for(int fn, int code);
    int a;
    a = (code >= 32768) ? code - 65536 : code;
    if (fn == 3) return "R8";
    if (a < -2048) return "R5";
    if (a >= 2048) return "R6";
    if ((code & 255) == 0) return "R9";
    return "R3";
  endfunction

  task automatic apply_check(input int fn, input int code, input string tag, input int tol);
    int got, exp_v, d;
    arg_q = 16'(code);
    fsel  = 2'(fn);
    #1;
    got   = int'($signed(res_q));
    exp_v = ref_eval(fn, code);
    d = got - exp_v;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      errors++;
      $display("FAIL %s fsel=%0d arg=0x%04h got %0d expected %0d", tag, fn, code, got, exp_v);
    end
  endtask

  task automatic fixed_check(input int fn, input int code, input int want, input string tag);
    int got;
    arg_q = 16'(code);
    fsel  = 2'(fn);
    #1;
    got = int'($signed(res_q));
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s fsel=%0d arg=0x%04h got %0d expected %0d", tag, fn, code, got, want);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    @(negedge clk);
    // Idle state at zero argument (R1): sigmoid(0) = 0.5
    fixed_check(0, 16'h0000, 128, "R1");
    fixed_check(0, 16'h0100, 187, "R1");
    fixed_check(1, 16'hFF00, -195, "R4");
    fixed_check(2, 16'h0400, 13977, "R4");
    // Segment 11 at 3.5: 244 + floor(7*128/256) = 247
    fixed_check(0, 16'h0380, 247, "R2");
    // Segment 0 at -7.5 for tanh: flat -256
    fixed_check(1, 16'hF880, -256, "R2");
    // exp near top of segment 12: 13977 + floor(18790*255/256)
    fixed_check(2, 16'h04FF, 32693, "R7");
    fixed_check(2, 16'h7FFF, 32767, "R7");
    fixed_check(2, 16'h0500, 32767, "R7");
    fixed_check(0, 16'h8000, 0, "R5");
    fixed_check(1, 16'hF7FF, -256, "R5");
    fixed_check(1, 16'h0800, 256, "R6");
    fixed_check(3, 16'h0180, 0, "R8");
    fixed_check(3, 16'h8000, 0, "R8");
    fixed_check(1, 16'h0000, 0, "R9");
    // Full sweep of every argument code for each select
    for (int fn = 0; fn < 4; fn++) begin
      for (int c = 0; c < 65536; c++) begin
        apply_check(fn, c, tag_for(fn, c), 1);
      end
    end
    // Randomized mix of selects and codes
    for (int i = 0; i < 2000; i++) begin
      int fn, c;
      fn = int'($urandom % 4);
      c  = int'($urandom & 32'hFFFF);
      apply_check(fn, c, tag_for(fn, c), 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule